// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor's word-addressed load/store port and a main-memory port that moves one word per request/acknowledge beat. Each cache line keeps a valid flag, a dirty flag, a tag and a block of several words. An access that finds its line present and its tag equal is answered in the same cycle. An access that misses stalls the processor while the controller brings the whole block in from memory. If the line being replaced holds modified data, that data is first copied back to memory.

Write misses allocate. The block is fetched first, and then the new word is merged into it through the normal hit path, so the line becomes dirty. Memory only sees the modified words when that line is later evicted. The `EARLY` parameter selects how a read miss is answered. With `EARLY=1` the requested word is handed to the processor in the beat in which it arrives from memory. With `EARLY=0` the reply waits until the whole block is stored.

Top module: `dmc_cache`

## Requirements
- R1: An address `a` maps to the line index `(a / WPB) mod LINES`, the word offset `a mod WPB` and the tag `a / (WPB*LINES)`. `LINES` and `WPB` are powers of two.
- R2: An access hits only when the indexed line is valid and its tag equals the address tag. A hit raises `cpu_hit` and `cpu_ack` in its first cycle, without stalling and without any memory request. A write hit updates the word in that same cycle.
- R3: On a miss `cpu_miss` pulses in the first cycle. The controller then reads all `WPB` words of the block, offsets 0 upward, at block-aligned memory word addresses. It holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until each `mem_ack`. Afterwards the line is valid with the new tag, and later accesses to any word of the block hit.
- R4: A write miss fetches the block first and then merges the written word. No memory write happens for the written word at that point, and a later read returns the new value.
- R5: A write sets the line's dirty flag. Memory keeps its old value for that word until the line is evicted.
- R6: Evicting a dirty line writes all `WPB` words of the old block to its own memory addresses. This write-back completes before the first refill read is issued.
- R7: Evicting a clean line issues no memory write.
- R8: With `EARLY=1` a read miss is answered in the cycle its word arrives, while the refill is still running (`mem_req` high). A write miss is answered only after the block is stored.
- R9: With `EARLY=0` a miss is answered only after the last refill beat, when `mem_req` is already low.
- R10: `cpu_stall` is high in every cycle in which a request is present and not answered, including the cycle of miss detection. It is low in the answering cycle.
- R11: Reset (synchronous, active high) clears every valid and dirty flag and leaves the memory port idle, so the first access to any address misses.
- R12: With 8 one-word lines starting empty, the read addresses 22, 26, 22, 26, 16, 3, 16, 18 give miss, miss, hit, hit, miss, miss, hit, miss. Address 18 evicts 26, so a following read of 26 misses and a read of 22 hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_stall | output | 1 | Request present and not yet answered |
| cpu_ack | output | 1 | Access answered this cycle |
| cpu_hit | output | 1 | First-cycle lookup hit |
| cpu_miss | output | 1 | First-cycle lookup miss |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | AW | Memory word address of the beat |
| mem_wdata | output | DW | Write-back data |
| mem_ack | input | 1 | Beat completed |
| mem_rdata | input | DW | Refill data, valid with `mem_ack` |

## Verification
With early restart, answering the processor and continuing the refill overlap. The forwarded reply arrives in a cycle in which memory beats are still outstanding, and the next processor request arrives while the line is still being filled. The bench issues a read at offset 2 of a four-word block and requires `mem_req` to still be high at the answer. It then immediately requests a neighbouring word of the same block. That request must stall with neither hit nor miss reported, and it must then be answered from the completed line with the memory value. A dirty-victim write miss is also run while the bench watches the memory port. Any write beat that follows a read beat within the same miss is counted as a failure.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } dmc_state_e;

    // field width for a count, never below one bit
    function automatic int unsigned dmc_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int unsigned LINES = 8,
    parameter int unsigned TAG_W = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // R11: leaving reset, no line is present or modified
    a_r11_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_q == '0 && dirty_q == '0));

    // R5: a modified line is always a present line
    a_r5_dirty_valid: assert property (@(posedge clk) disable iff (rst)
        (dirty_q & ~valid_q) == '0);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned DA_W  = 3
) (
    input  logic            clk,
    input  logic [DA_W-1:0] rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [DA_W-1:0] wr_addr,
    input  logic [DW-1:0]   wr_data
);
    logic [DW-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) word_q[wr_addr] <= wr_data;
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned LINES = 8,
    parameter int unsigned WPB   = 1,
    parameter int unsigned EARLY = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_stall,
    output logic          cpu_ack,
    output logic          cpu_hit,
    output logic          cpu_miss,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int unsigned IDX_W = dmc_width(LINES);
    localparam int unsigned OFF_W = dmc_width(WPB);
    localparam int unsigned TAG_W = AW - $clog2(LINES) - $clog2(WPB);
    localparam int unsigned DEPTH = LINES * WPB;
    localparam int unsigned DA_W  = dmc_width(DEPTH);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WPB - 1);

    dmc_state_e       state;
    logic [OFF_W-1:0] beat;
    logic [IDX_W-1:0] req_idx_q;
    logic [TAG_W-1:0] req_tag_q;
    logic [OFF_W-1:0] req_off_q;
    logic             req_we_q;
    logic [TAG_W-1:0] vic_tag_q;
    logic             retry;

    logic [IDX_W-1:0] lk_idx, idx_sel;
    logic [TAG_W-1:0] lk_tag, rd_tag, mem_tag;
    logic [OFF_W-1:0] lk_off, da_off;
    logic [DA_W-1:0]  da_addr;
    logic [DW-1:0]    ds_rdata;
    logic             rd_valid, rd_dirty;
    logic             hit_raw, miss_now, fwd_now, last_ack;
    logic             ts_we, ds_we;

    // R1: address split
    assign lk_off = OFF_W'(32'(cpu_addr) % WPB);
    assign lk_idx = IDX_W'((32'(cpu_addr) / WPB) % LINES);
    assign lk_tag = TAG_W'(32'(cpu_addr) / (WPB * LINES));

    assign idx_sel = (state == ST_IDLE) ? lk_idx : req_idx_q;
    assign da_off  = (state == ST_IDLE) ? lk_off : beat;
    assign da_addr = DA_W'(32'(idx_sel) * WPB + 32'(da_off));

    // R2: lookup
    assign hit_raw  = (state == ST_IDLE) && cpu_req && rd_valid && (rd_tag == lk_tag);
    assign miss_now = (state == ST_IDLE) && cpu_req && !hit_raw;
    assign last_ack = mem_ack && (beat == LAST_BEAT);
    assign fwd_now  = (EARLY != 0) && (state == ST_FILL) && mem_ack
                      && !req_we_q && (beat == req_off_q);

    assign ts_we = (hit_raw && cpu_we) || ((state == ST_FILL) && last_ack);
    assign ds_we = (hit_raw && cpu_we) || ((state == ST_FILL) && mem_ack);

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx_sel),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .wr_en    (ts_we),
        .wr_idx   (idx_sel),
        .wr_tag   ((state == ST_IDLE) ? lk_tag : req_tag_q),
        .wr_dirty (state == ST_IDLE)
    );

    dmc_data_store #(.DEPTH(DEPTH), .DW(DW), .DA_W(DA_W)) u_data (
        .clk     (clk),
        .rd_addr (da_addr),
        .rd_data (ds_rdata),
        .wr_en   (ds_we),
        .wr_addr (da_addr),
        .wr_data ((state == ST_IDLE) ? cpu_wdata : mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            beat      <= '0;
            req_idx_q <= '0;
            req_tag_q <= '0;
            req_off_q <= '0;
            req_we_q  <= 1'b0;
            vic_tag_q <= '0;
            retry     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    retry <= 1'b0;
                    if (miss_now) begin
                        req_idx_q <= lk_idx;
                        req_tag_q <= lk_tag;
                        req_off_q <= lk_off;
                        req_we_q  <= cpu_we;
                        vic_tag_q <= rd_tag;
                        beat      <= '0;
                        state     <= (rd_valid && rd_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        beat <= last_ack ? '0 : beat + 1'b1;
                        if (last_ack) state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        beat <= beat + 1'b1;
                        if (last_ack) begin
                            state <= ST_IDLE;
                            retry <= !((EARLY != 0) && !req_we_q);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_tag   = (state == ST_WBACK) ? vic_tag_q : req_tag_q;
    assign mem_req   = (state != ST_IDLE);
    assign mem_we    = (state == ST_WBACK);
    assign mem_addr  = AW'((32'(mem_tag) * LINES + 32'(req_idx_q)) * WPB + 32'(beat));
    assign mem_wdata = ds_rdata;

    assign cpu_ack   = hit_raw || fwd_now;
    assign cpu_hit   = hit_raw && !retry;
    assign cpu_miss  = miss_now;
    assign cpu_stall = cpu_req && !cpu_ack;
    assign cpu_rdata = fwd_now ? mem_rdata : ds_rdata;

    // R10: a detected miss keeps the held request stalled next cycle
    a_r10_stall_after_miss: assert property (@(posedge clk) disable iff (rst)
        cpu_miss |=> (cpu_stall || !cpu_req));

    // R6: refill starts only after the final write-back beat was acknowledged
    a_r6_wb_before_fill: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && $past(state) == ST_WBACK) |-> $past(mem_ack && beat == LAST_BEAT));

    // R3: beat request held steady until acknowledged
    a_r3_beat_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2: a hit leaves the memory port idle on the next cycle
    a_r2_hit_quiet: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |=> !mem_req);

    // R8 / R9: answering during memory activity only for early-restart reads
    a_r9_ack_timing: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && mem_req) |-> ((EARLY != 0) && !mem_we && !req_we_q));

endmodule

// File: tb/dmc_cache_tb.sv
`timescale 1ns/100ps

module dmc_mem_model #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];
    int wr_cnt;

    initial begin
        ack = 1'b0;
        rdata = '0;
        wr_cnt = 0;
        for (int i = 0; i < 2**AW; i++) mem[i] = 32'hA000_0000 + i;
    end

    always @(posedge clk) begin
        ack   <= req && !ack;
        rdata <= mem[addr];
        if (req && we && !ack) begin
            mem[addr] <= wdata;
            wr_cnt    <= wr_cnt + 1;
        end
    end
endmodule

module dmc_cache_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [2:0]  req = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [2:0]  stall, ack, hit, miss, mreq, mwe, mack;
    logic [31:0] rdata [3];
    logic [7:0]  maddr [3];
    logic [31:0] mwdata [3];
    logic [31:0] mrdata [3];
    logic [31:0] shadow [3][256];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    dmc_cache #(.AW(8), .DW(32), .LINES(8), .WPB(1), .EARLY(0)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(req[0]), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_stall(stall[0]), .cpu_ack(ack[0]), .cpu_hit(hit[0]),
        .cpu_miss(miss[0]), .cpu_rdata(rdata[0]), .mem_req(mreq[0]), .mem_we(mwe[0]),
        .mem_addr(maddr[0]), .mem_wdata(mwdata[0]), .mem_ack(mack[0]), .mem_rdata(mrdata[0]));
    dmc_mem_model u_mem0 (.clk(clk), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]),
        .wdata(mwdata[0]), .ack(mack[0]), .rdata(mrdata[0]));

    dmc_cache #(.AW(8), .DW(32), .LINES(4), .WPB(4), .EARLY(1)) u_dut_er (
        .clk(clk), .rst(rst), .cpu_req(req[1]), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_stall(stall[1]), .cpu_ack(ack[1]), .cpu_hit(hit[1]),
        .cpu_miss(miss[1]), .cpu_rdata(rdata[1]), .mem_req(mreq[1]), .mem_we(mwe[1]),
        .mem_addr(maddr[1]), .mem_wdata(mwdata[1]), .mem_ack(mack[1]), .mem_rdata(mrdata[1]));
    dmc_mem_model u_mem1 (.clk(clk), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]),
        .wdata(mwdata[1]), .ack(mack[1]), .rdata(mrdata[1]));

    dmc_cache #(.AW(8), .DW(32), .LINES(4), .WPB(4), .EARLY(0)) u_dut_fb (
        .clk(clk), .rst(rst), .cpu_req(req[2]), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_stall(stall[2]), .cpu_ack(ack[2]), .cpu_hit(hit[2]),
        .cpu_miss(miss[2]), .cpu_rdata(rdata[2]), .mem_req(mreq[2]), .mem_we(mwe[2]),
        .mem_addr(maddr[2]), .mem_wdata(mwdata[2]), .mem_ack(mack[2]), .mem_rdata(mrdata[2]));
    dmc_mem_model u_mem2 (.clk(clk), .req(mreq[2]), .we(mwe[2]), .addr(maddr[2]),
        .wdata(mwdata[2]), .ack(mack[2]), .rdata(mrdata[2]));

    function automatic logic [31:0] mem_word(input int d, input int a);
        case (d)
            0: return u_mem0.mem[a];
            1: return u_mem1.mem[a];
            default: return u_mem2.mem[a];
        endcase
    endfunction

    function automatic int mem_writes(input int d);
        case (d)
            0: return u_mem0.wr_cnt;
            1: return u_mem1.wr_cnt;
            default: return u_mem2.wr_cnt;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one processor access; records first-cycle hit/miss, answer data, port state at answer
    task automatic access(input int d, input bit we, input logic [7:0] a, input logic [31:0] wd,
                          output bit h, output bit m, output logic [31:0] rd, output int cyc,
                          output bit mreq_at_ack, output bit order_bad, output bit stall_bad);
        bit saw_rd = 0;
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; req[d] = 1'b1;
        cyc = 0; order_bad = 0; stall_bad = 0; h = 0; m = 0; rd = '0; mreq_at_ack = 0;
        while (1) begin
            #1;
            if (cyc == 0) begin h = hit[d]; m = miss[d]; end
            if (mreq[d] && !mwe[d]) saw_rd = 1;
            if (mreq[d] && mwe[d] && saw_rd) order_bad = 1;
            if (ack[d]) begin
                rd = rdata[d];
                mreq_at_ack = mreq[d];
                if (stall[d]) stall_bad = 1;
                break;
            end
            if (!stall[d]) stall_bad = 1;
            cyc++;
            if (cyc > 400) begin
                chk(0, "R10 access hung", 32'(cyc), 32'd400);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        req[d] = 1'b0;
        if (we) shadow[d][a] = wd;
    endtask

    task automatic quiesce(input int d);
        int n = 0;
        while (mreq[d] && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset();
        for (int d = 0; d < 3; d++) begin
            chk(mreq[d] == 1'b0, "R11 mem port idle after reset", 32'(mreq[d]), 32'd0);
            chk(stall[d] == 1'b0 && ack[d] == 1'b0, "R11 no stall/ack after reset",
                32'({stall[d], ack[d]}), 32'd0);
        end
    endtask

    task automatic t_sequence();
        logic [7:0] seq [8] = '{8'd22, 8'd26, 8'd22, 8'd26, 8'd16, 8'd3, 8'd16, 8'd18};
        bit exp_h [8] = '{0, 0, 1, 1, 0, 0, 1, 0};
        bit h, m, mq, ob, sb; logic [31:0] rd; int cyc;
        for (int i = 0; i < 8; i++) begin
            access(0, 0, seq[i], '0, h, m, rd, cyc, mq, ob, sb);
            chk(h == exp_h[i] && m == !exp_h[i], "R12 hit/miss pattern", 32'({h, m}), 32'({exp_h[i], !exp_h[i]}));
            chk(rd == shadow[0][seq[i]], "R1 R3 read data", rd, shadow[0][seq[i]]);
            chk(!sb, "R10 stall shape", 32'(sb), 32'd0);
        end
        access(0, 0, 8'd26, '0, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1, "R12 26 evicted by 18", 32'(m), 32'd1);
        access(0, 0, 8'd22, '0, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && cyc == 0, "R2 22 still resident, one cycle", 32'(cyc), 32'd0);
    endtask

    task automatic t_writeback();
        bit h, m, mq, ob, sb; logic [31:0] rd; int cyc; int w0;
        w0 = mem_writes(0);
        access(0, 1, 8'd5, 32'h5555_0005, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1, "R4 write miss detected", 32'(m), 32'd1);
        chk(mem_writes(0) == w0, "R4 no memory write on allocate", 32'(mem_writes(0)), 32'(w0));
        chk(mem_word(0, 5) == 32'hA000_0005, "R5 memory keeps old word", mem_word(0, 5), 32'hA000_0005);
        access(0, 0, 8'd5, '0, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && rd == 32'h5555_0005, "R4 merged word read back", rd, 32'h5555_0005);
        access(0, 0, 8'd13, '0, h, m, rd, cyc, mq, ob, sb);
        chk(mem_writes(0) == w0 + 1, "R6 dirty victim written", 32'(mem_writes(0)), 32'(w0 + 1));
        chk(mem_word(0, 5) == 32'h5555_0005, "R6 victim data in memory", mem_word(0, 5), 32'h5555_0005);
        chk(rd == shadow[0][13], "R3 refill after write-back", rd, shadow[0][13]);
        access(0, 0, 8'd5, '0, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1 && rd == 32'h5555_0005, "R6 reload of written-back word", rd, 32'h5555_0005);
        chk(mem_writes(0) == w0 + 1, "R7 clean eviction writes nothing", 32'(mem_writes(0)), 32'(w0 + 1));
        access(0, 1, 8'd5, 32'h6666_0005, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && cyc == 0 && !mq, "R2 write hit in one cycle", 32'(cyc), 32'd0);
    endtask

    task automatic t_early();
        bit h, m, mq, ob, sb; logic [31:0] rd; int cyc;
        access(1, 0, 8'h12, '0, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1 && mq == 1'b1, "R8 forwarded during refill", 32'(mq), 32'd1);
        chk(rd == shadow[1][8'h12], "R8 forwarded data", rd, shadow[1][8'h12]);
        access(1, 0, 8'h13, '0, h, m, rd, cyc, mq, ob, sb);
        chk(!h && !m && cyc > 0, "R10 request during refill stalls", 32'(cyc), 32'd1);
        chk(rd == shadow[1][8'h13] && !sb, "R3 neighbour from completed line", rd, shadow[1][8'h13]);
        quiesce(1);
        access(1, 1, 8'h31, 32'hBEEF_0031, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1 && mq == 1'b0, "R8 write miss waits for block", 32'(mq), 32'd0);
        access(1, 0, 8'h31, '0, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && rd == 32'hBEEF_0031, "R4 merged in multiword line", rd, 32'hBEEF_0031);
    endtask

    task automatic t_full();
        bit h, m, mq, ob, sb; logic [31:0] rd; int cyc; int w0;
        access(2, 0, 8'h12, '0, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1 && mq == 1'b0, "R9 answer after whole block", 32'(mq), 32'd0);
        chk(rd == shadow[2][8'h12], "R9 read data", rd, shadow[2][8'h12]);
        access(2, 0, 8'h11, '0, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && rd == shadow[2][8'h11], "R3 other word of block hits", rd, shadow[2][8'h11]);
        access(2, 1, 8'h05, 32'hD2D2_0005, h, m, rd, cyc, mq, ob, sb);
        w0 = mem_writes(2);
        access(2, 1, 8'h25, 32'hD3D3_0025, h, m, rd, cyc, mq, ob, sb);
        chk(m == 1'b1 && !ob, "R6 write-back before refill", 32'(ob), 32'd0);
        chk(mem_writes(2) == w0 + 4, "R6 whole block written back", 32'(mem_writes(2)), 32'(w0 + 4));
        for (int a = 4; a < 8; a++)
            chk(mem_word(2, a) == shadow[2][a], "R6 victim words in memory", mem_word(2, a), shadow[2][a]);
        access(2, 0, 8'h25, '0, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && rd == 32'hD3D3_0025, "R4 merged word", rd, 32'hD3D3_0025);
        access(2, 0, 8'h24, '0, h, m, rd, cyc, mq, ob, sb);
        chk(h == 1'b1 && rd == shadow[2][8'h24], "R3 fetched neighbour", rd, shadow[2][8'h24]);
    endtask

    initial begin
        for (int d = 0; d < 3; d++)
            for (int a = 0; a < 256; a++) shadow[d][a] = 32'hA000_0000 + a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_sequence();
        t_writeback();
        t_early();
        t_full();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule